// File: doc/BRIEF.md
# Open-Drain Serial Byte Transmitter with Collision Abort

This block sends one byte in asynchronous serial format on a single shared wire. The wire has an external pull-up, and every node on it can only pull it low, so the wire behaves as a wired-AND. The frame is one start bit (low), eight data bits with the least significant bit first, and one stop bit (released). The block never drives the wire high. Its pad output value is tied low, and the only thing the block controls is the output enable, `drive_en`. For a 0 it asserts the enable, and for a 1 it releases the line.

Another node may pull the wire low while this block is sending a 1. To catch this, the block reads the wire back through a two-stage synchroniser in the middle of every released data bit. If the wire reads low at that point, the byte stops at once. The line is left released, and the block reports the end of the byte with a collision flag. Packet framing and bus arbitration are left to the logic around the block.

A byte is offered with `tx_valid`/`tx_ready`. A single-cycle `done` marks the end of every byte. `collision` is raised in the same cycle as `done` when the byte was aborted.

Top module: `wired_and_tx`

## Requirements
- R1: After reset, `drive_en`, `done` and `collision` are 0 and `tx_ready` is 1.
- R2: A byte is taken at a clock edge only when `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the cycle after acceptance until the cycle in which `done` is 1, and it returns to 1 in that same cycle. A `tx_valid` held high with other data while the block is busy does not change the wave being sent.
- R3: The start bit asserts `drive_en` for exactly BIT_CYCLES cycles, starting in the cycle after acceptance.
- R4: Data bit i (i = 0..7, LSB first) occupies cycles (i+1)·BIT_CYCLES to (i+2)·BIT_CYCLES−1 after acceptance. `drive_en` is 1 for a 0 bit and 0 for a 1 bit.
- R5: The stop bit keeps `drive_en` at 0 for BIT_CYCLES cycles. `done` is then 1, with `collision` 0, in cycle 10·BIT_CYCLES after acceptance.
- R6: In a data bit of value 1, the wire level during cycle HALF = floor(BIT_CYCLES/2) of that bit is sampled through two flops. If that level is low, `done` and `collision` are both 1 in cycle HALF+3 of that bit, and no further bits are sent.
- R7: A low wire at any other time does not raise `collision` and does not change the wave. This covers the start bit, 0 data bits, the stop bit, and every cycle of a 1 bit other than cycle HALF.
- R8: Whenever the block is idle (`tx_ready` = 1), including right after an abort, `drive_en` is 0.
- R9: `done` lasts exactly one cycle, and `collision` is never 1 without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | DATA_BITS | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Block is idle and will accept a byte |
| line_in | input | 1 | Level of the shared wire (asynchronous) |
| drive_en | output | 1 | Pad output enable; the pad value is fixed low |
| done | output | 1 | One-cycle pulse at the end of every byte |
| collision | output | 1 | With `done`: the byte was aborted by a collision |

## Verification
A wrong bit counter or shift register shows up as a `drive_en` wave that differs from the expected frame within one bit period of the fault. A misplaced read-back point shows up as a collision either missed or reported when the wire is pulled low for a single cycle just before, at, or just after the mid-bit sample. A sequencer that fails to return to idle keeps `tx_ready` low, or leaves `drive_en` high, past the cycle where `done` is expected. Comparing every output in every cycle exposes any of these no later than the end of the affected byte.

// File: rtl/wired_and_tx_pkg.sv
package wired_and_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_t;
endpackage

// File: rtl/wired_and_tx_sync.sv
module wired_and_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/wired_and_tx_timer.sv
module wired_and_tx_timer #(
  parameter int BIT_CYCLES = 1085,
  parameter int PROBE_AT   = 544
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic bit_end,
  output logic probe
);
  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST  = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] PROBE = CW'(PROBE_AT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt <= '0;
    else if (bit_end) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign bit_end = (cnt == LAST);
  assign probe   = (cnt == PROBE);
endmodule

// File: rtl/wired_and_tx_fsm.sv
module wired_and_tx_fsm
  import wired_and_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  input  logic                 bit_end,
  input  logic                 probe,
  input  logic                 line_s,
  output logic                 idle,
  output logic                 tx_ready,
  output logic                 drive_en,
  output logic                 done,
  output logic                 collision
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

  tx_phase_t            phase;
  logic [DATA_BITS-1:0] shreg;
  logic [IW-1:0]        idx;

  assign idle = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      shreg     <= '0;
      idx       <= '0;
      tx_ready  <= 1'b1;
      drive_en  <= 1'b0;
      done      <= 1'b0;
      collision <= 1'b0;
    end else begin
      done      <= 1'b0;
      collision <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          drive_en <= 1'b0;
          if (tx_valid) begin
            shreg    <= tx_data;
            phase    <= PH_START;
            drive_en <= 1'b1;
            tx_ready <= 1'b0;
          end
        end
        PH_START: begin
          if (bit_end) begin
            phase    <= PH_DATA;
            idx      <= '0;
            drive_en <= ~shreg[0];
          end
        end
        PH_DATA: begin
          if (probe && shreg[0] && !line_s) begin
            phase     <= PH_IDLE;
            drive_en  <= 1'b0;
            tx_ready  <= 1'b1;
            done      <= 1'b1;
            collision <= 1'b1;
          end else if (bit_end) begin
            if (idx == LAST_IDX) begin
              phase    <= PH_STOP;
              drive_en <= 1'b0;
            end else begin
              shreg    <= shreg >> 1;
              idx      <= idx + 1'b1;
              drive_en <= ~shreg[1];
            end
          end
        end
        PH_STOP: begin
          if (bit_end) begin
            phase    <= PH_IDLE;
            tx_ready <= 1'b1;
            done     <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wired_and_tx.sv
module wired_and_tx #(
  parameter int DATA_BITS   = 8,
  parameter int BIT_CYCLES  = 1085,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 line_in,
  output logic                 drive_en,
  output logic                 done,
  output logic                 collision
);
  localparam int HALF     = BIT_CYCLES / 2;
  localparam int PROBE_AT = HALF + SYNC_STAGES;

  initial begin
    if (PROBE_AT > BIT_CYCLES - 1)
      $error("BIT_CYCLES too short for the read-back latency");
  end

  logic line_s;
  logic bit_end;
  logic probe;
  logic idle;

  wired_and_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (line_in),
    .sync_out (line_s)
  );

  wired_and_tx_timer #(.BIT_CYCLES(BIT_CYCLES), .PROBE_AT(PROBE_AT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .hold    (idle),
    .bit_end (bit_end),
    .probe   (probe)
  );

  wired_and_tx_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .bit_end   (bit_end),
    .probe     (probe),
    .line_s    (line_s),
    .idle      (idle),
    .tx_ready  (tx_ready),
    .drive_en  (drive_en),
    .done      (done),
    .collision (collision)
  );
endmodule

// File: rtl/wired_and_tx_checker.sv
module wired_and_tx_checker (
  input logic clk,
  input logic rst,
  input logic tx_valid,
  input logic tx_ready,
  input logic drive_en,
  input logic done,
  input logic collision
);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_ready_with_done_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> tx_ready);

  p_start_drives_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> drive_en);

  p_abort_released_r6: assert property (@(posedge clk) disable iff (rst)
    collision |-> !drive_en);

  p_idle_released_r8: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !drive_en);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_col_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
    collision |-> done);
endmodule

bind wired_and_tx wired_and_tx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .drive_en  (drive_en),
  .done      (done),
  .collision (collision)
);

// File: tb/wired_and_tx_bench.sv
`timescale 1ns/1ps
module wired_and_tx_bench;
  localparam int B    = 8;
  localparam int HALF = B / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       drive_en;
  logic       done;
  logic       collision;
  logic       jam = 1'b0;
  logic       line_in;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  assign line_in = ~(drive_en | jam);

  always #4 clk = ~clk;

  wired_and_tx #(.DATA_BITS(8), .BIT_CYCLES(B), .SYNC_STAGES(2)) u_wired_and_tx (
    .clk       (clk),
    .rst       (rst),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .line_in   (line_in),
    .drive_en  (drive_en),
    .done      (done),
    .collision (collision)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "drive_en", int'(drive_en), 0);
    chk(req, "tx_ready", int'(tx_ready), 1);
    chk(req, "done", int'(done), 0);
    chk(req, "collision", int'(collision), 0);
  endtask

  // Send byte b; the wire is also pulled low by another node in cycles [js, je)
  // after acceptance. With junk set, a different byte is offered while busy.
  task automatic run_byte(input logic [7:0] b, input int js, input int je, input bit junk);
    int  end_t;
    bit  col;
    int  k;
    int  exp_d;
    string rq;
    col   = 1'b0;
    end_t = 10 * B;
    for (int i = 1; i <= 8; i++) begin
      if (!col && b[i-1] && (i*B + HALF >= js) && (i*B + HALF < je)) begin
        col   = 1'b1;
        end_t = i*B + HALF + 3;
      end
    end
    @(negedge clk);
    chk("R2", "tx_ready before offer", int'(tx_ready), 1);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    for (int t = 0; t <= end_t; t++) begin
      jam = (t >= js) && (t < je);
      if (junk && t < 5*B && t < end_t) begin
        tx_valid = 1'b1;
        tx_data  = ~b;
      end else begin
        tx_valid = 1'b0;
      end
      if (t < end_t) begin
        k = t / B;
        if (k == 0) begin exp_d = 1; rq = "R3"; end
        else if (k <= 8) begin exp_d = b[k-1] ? 0 : 1; rq = "R4"; end
        else begin exp_d = 0; rq = "R5"; end
        chk(rq, "drive_en", int'(drive_en), exp_d);
        chk("R2", "tx_ready busy", int'(tx_ready), 0);
        chk(col ? "R7" : "R5", "done early", int'(done), 0);
        chk("R7", "collision early", int'(collision), 0);
      end else begin
        chk("R8", "drive_en at end", int'(drive_en), 0);
        chk("R2", "tx_ready at end", int'(tx_ready), 1);
        chk(col ? "R6" : "R5", "done", int'(done), 1);
        chk(col ? "R6" : "R5", "collision", int'(collision), col ? 1 : 0);
      end
      @(negedge clk);
    end
    jam      = 1'b0;
    tx_valid = 1'b0;
    chk_idle("R9");
    @(negedge clk);
    chk_idle("R8");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1");

    // R3 R4 R5 R2: every byte value, busy-time offers on odd values
    for (int v = 0; v < 256; v++)
      run_byte(8'(v), -1, -1, v[0]);

    // R6: single-cycle pull exactly at the mid-bit sample of each 1 bit
    for (int i = 1; i <= 8; i++)
      run_byte(8'hFF, i*B + HALF, i*B + HALF + 1, 1'b0);

    // R7: pull one cycle before and everywhere after the sample point
    for (int i = 1; i <= 8; i++) begin
      run_byte(8'hFF, i*B + HALF - 1, i*B + HALF, 1'b0);
      run_byte(8'hFF, i*B + HALF + 1, i*B + B, 1'b0);
    end

    // R7: pull during the whole frame of a byte made of 0 bits
    run_byte(8'h00, 0, 10*B, 1'b0);
    // R7: pull during start bit and stop bit only
    run_byte(8'hFF, 0, B, 1'b0);
    run_byte(8'hFF, 9*B, 10*B, 1'b0);
    // R6: mixed byte, wire held low from bit 3 on (first 1 at bit 2 -> data index 2)
    run_byte(8'hA4, 3*B, 10*B, 1'b1);
    // R6 R2: busy-time offer during an aborted byte, then a clean byte
    run_byte(8'h81, B, 2*B, 1'b1);
    run_byte(8'h5A, -1, -1, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule